// File: doc/BRIEF.md
# Eight-Bit Bidirectional GPIO Port

This block is a memory-mapped general-purpose I/O port of eight pins. Each pin can be an input or an output on its own. Software sees three registers on a small register bus. The direction register picks which pins are driven. The latch register holds the values to drive. The pin-level register returns the sampled pin states.

The latch and the pin levels are read back through separate addresses. A read-modify-write on the latch address therefore works on the driven value, whatever the pins actually show. Two side inputs change what a read returns:
- A per-bit analog-select vector forces pin-level reads of those bits to zero, while the drivers stay under the direction register.
- A claim input hands one designated pin to another function. While claimed, that pin reads zero in all three registers, its driver is released, and bus writes to its bits are dropped.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register is all ones (every pin an input, `pinOe` all zero), the latch is all zeros (`pinOut` zero) and `busRdata` is zero.
- R2: `pinOe[i]` is the inverse of direction bit i, so 0 drives and 1 releases. It takes effect on the edge after a write to address 2.
- R3: A write to address 0 or to address 1 loads `busWdata` into the output latch. `pinOut` carries the latch from the following cycle.
- R4: `busRdata` is registered. It shows the addressed value in the cycle after `busRe` and is zero after a cycle without `busRe`. Address 0 returns the pin levels through a two-flop synchronizer, so a pin change becomes readable no earlier than two edges after it occurs.
- R5: A read of address 1 returns the latch contents, not the pin levels.
- R6: A read of address 2 returns the direction register.
- R7: Bits with `anaSel` high read 0 at address 0. Their `pinOe` still follows the direction register.
- R8: While `altClaim` is high, bit 6 (the designated pin) reads 0 at addresses 0, 1 and 2, and `pinOe[6]` and `pinOut[6]` are 0.
- R9: While `altClaim` is high, writes leave the latch and direction bits of bit 6 unchanged. Their earlier values return when the claim is released.
- R10: Address 3 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 pin level, 1 latch, 2 direction |
| busWe | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 8 | Registered read data |
| pinIn | input | 8 | Sampled pin levels, asynchronous |
| pinOut | output | 8 | Value presented to the pin drivers |
| pinOe | output | 8 | Driver enable per pin, 1 drives |
| anaSel | input | 8 | Per-bit analog selection |
| altClaim | input | 1 | Designated pin owned by another function |

## Verification
The hardest situation to produce is a write that is dropped for the claimed pin. The dropped write is invisible while the claim lasts, because every view of that bit is forced to zero. The stimulus first loads a 1 into the bit's latch and direction bits and raises the claim. It then writes 0 to both registers and releases the claim. Only then can a read show whether the old 1 survived. Synchronizer latency is checked by reading immediately after a pin change and expecting the previous level.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLat;
    logic    wrDir;
    logic    rdEn;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic                  busRe,
  output portStrobe_t           strobe
);

  regSel_e sel;

  always_comb begin
    sel          = regSel_e'(busAddr);
    strobe       = '0;
    strobe.rdEn  = busRe;
    strobe.rdSel = sel;
    if (busWe) begin
      unique case (sel)
        SEL_PIN, SEL_LAT: strobe.wrLat = 1'b1;
        SEL_DIR:          strobe.wrDir = 1'b1;
        default:          ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int CLAIM_BIT = 6,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] anaSel,
  input  logic             altClaim,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] rdData
);

  localparam logic [WIDTH-1:0] CLAIM_ONE = WIDTH'(1) << CLAIM_BIT;

  logic [WIDTH-1:0] claimMask;
  logic [WIDTH-1:0] latQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] selView;

  assign claimMask = altClaim ? CLAIM_ONE : '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bitWrOk;
    logic [SYNC_LEN-1:0] syncQ;

    assign bitWrOk = ~claimMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latQ[i] <= 1'b0;
        dirQ[i] <= 1'b1;
        syncQ   <= '0;
      end else begin
        if (strobe.wrLat && bitWrOk) latQ[i] <= wrData[i];
        if (strobe.wrDir && bitWrOk) dirQ[i] <= wrData[i];
        syncQ <= {syncQ[SYNC_LEN-2:0], pinIn[i]};
      end
    end

    assign pinSync[i] = syncQ[SYNC_LEN-1];
  end

  assign pinOe   = ~dirQ & ~claimMask;
  assign pinOut  = latQ & ~claimMask;
  assign pinView = pinSync & ~anaSel & ~claimMask;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_PIN: selView = pinView;
      SEL_LAT: selView = latQ & ~claimMask;
      SEL_DIR: selView = dirQ & ~claimMask;
      default: selView = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= selView;
    else                  rdData <= '0;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int CLAIM_BIT = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic [WIDTH-1:0]      busWdata,
  input  logic                  busRe,
  output logic [WIDTH-1:0]      busRdata,
  input  logic [WIDTH-1:0]      pinIn,
  output logic [WIDTH-1:0]      pinOut,
  output logic [WIDTH-1:0]      pinOe,
  input  logic [WIDTH-1:0]      anaSel,
  input  logic                  altClaim
);

  portStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strobe  (strobe)
  );

  gpio_port_dp #(
    .WIDTH     (WIDTH),
    .CLAIM_BIT (CLAIM_BIT),
    .SYNC_LEN  (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWdata),
    .pinIn    (pinIn),
    .anaSel   (anaSel),
    .altClaim (altClaim),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdData   (busRdata)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH     = 8,
  parameter int CLAIM_BIT = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWe,
  input logic [WIDTH-1:0] busWdata,
  input logic             busRe,
  input logic [WIDTH-1:0] busRdata,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] pinOe,
  input logic [WIDTH-1:0] anaSel,
  input logic             altClaim
);

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd2 && !altClaim) |=> (altClaim || pinOe == ~$past(busWdata)));

  p_lat_to_pin_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr == 2'd0 || busAddr == 2'd1) && !altClaim) |=> (altClaim || pinOut == $past(busWdata)));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> busRdata == '0);

  p_analog_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 2'd0) |=> (busRdata & $past(anaSel)) == '0);

  p_claim_drive_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    altClaim |-> (!pinOe[CLAIM_BIT] && !pinOut[CLAIM_BIT]));

  p_claim_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && altClaim) |=> !busRdata[CLAIM_BIT]);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 2'd3) |=> busRdata == '0);

  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd3) |=> ($stable(pinOe) && $stable(pinOut)) || $changed(altClaim));

endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH     (WIDTH),
  .CLAIM_BIT (CLAIM_BIT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRe    (busRe),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .anaSel   (anaSel),
  .altClaim (altClaim)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic       busRe = 1'b0;
  logic [7:0] busRdata;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [7:0] anaSel = 8'h2F;
  logic       altClaim = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .anaSel(anaSel), .altClaim(altClaim)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pinOe after reset", pinOe, 8'h00);
    check("R1 pinOut after reset", pinOut, 8'h00);
    check("R1 busRdata after reset", busRdata, 8'h00);
    busRead(2'd2, rv); check("R1 direction reset", rv, 8'hFF);
    busRead(2'd1, rv); check("R1 latch reset", rv, 8'h00);
    waitCycles(1);     check("R4 idle read data", busRdata, 8'h00);
  endtask

  task automatic t_direction;
    busWrite(2'd2, 8'h0F);
    check("R2 pinOe follows direction", pinOe, 8'hF0);
    busRead(2'd2, rv); check("R6 direction readback", rv, 8'h0F);
  endtask

  task automatic t_latch;
    busWrite(2'd1, 8'hA5);
    check("R3 latch write via addr 1", pinOut, 8'hA5);
    busWrite(2'd0, 8'h3C);
    check("R3 latch write via addr 0", pinOut, 8'h3C);
    busRead(2'd1, rv); check("R5 latch readback", rv, 8'h3C);
  endtask

  task automatic t_pinread;
    anaSel = 8'h00;
    pinIn  = 8'h96;
    waitCycles(3);
    busRead(2'd0, rv); check("R4 pin level read", rv, 8'h96);
    busRead(2'd1, rv); check("R5 latch differs from pins", rv, 8'h3C);
    @(negedge clk);
    pinIn = 8'h5A; busAddr = 2'd0; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    check("R4 synchronizer latency", busRdata, 8'h96);
    waitCycles(3);
    busRead(2'd0, rv); check("R4 pin level after sync", rv, 8'h5A);
  endtask

  task automatic t_analog;
    anaSel = 8'h2F;
    pinIn  = 8'hFF;
    waitCycles(3);
    busRead(2'd0, rv); check("R7 analog bits read zero", rv, 8'hD0);
    busWrite(2'd2, 8'h00);
    check("R7 analog bits still driven", pinOe, 8'hFF);
    anaSel = 8'h00;
    waitCycles(1);
  endtask

  task automatic t_claim;
    busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'h40);
    @(negedge clk); altClaim = 1'b1;
    waitCycles(1);
    check("R8 claimed pin driver off", pinOe, 8'hBF);
    check("R8 claimed pin output zero", pinOut, 8'hBF);
    busRead(2'd0, rv); check("R8 claimed pin level reads zero", rv, 8'hBF);
    busRead(2'd1, rv); check("R8 claimed latch reads zero", rv, 8'hBF);
    busRead(2'd2, rv); check("R8 claimed direction reads zero", rv, 8'h00);
  endtask

  task automatic t_claim_write;
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h00);
    check("R9 other bits written while claimed", pinOe, 8'hBF);
    @(negedge clk); altClaim = 1'b0;
    waitCycles(1);
    busRead(2'd1, rv); check("R9 latch bit kept", rv, 8'h40);
    busRead(2'd2, rv); check("R9 direction bit kept", rv, 8'h40);
    check("R9 released pin stays input", pinOe, 8'hBF);
  endtask

  task automatic t_unmapped;
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, rv); check("R10 unmapped read zero", rv, 8'h00);
    busRead(2'd1, rv); check("R10 latch untouched", rv, 8'h40);
    busRead(2'd2, rv); check("R10 direction untouched", rv, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_latch();
    t_pinread();
    t_analog();
    t_claim();
    t_claim_write();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule